// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

The block is a watchdog timer behind a small 16-bit register interface. Software sets it up through one control word. That word is guarded: a configuration write is accepted only when it directly follows a two-word unlock key written to the same register. While the counter runs, software keeps it alive with a second, distinct two-word key. This key clears the count and leaves the configuration as it is.

The timeout is a power of two of the input clock. It is chosen by a one-hot exponent field, and the eight selectable exponents are parameters, so a test setup can use short timeouts. On expiry the block sets an interrupt flag. If reset requests are enabled, it also issues a one-cycle system reset request and records the cause in a sticky status bit. That status bit is cleared only by power-on reset or by software, so it survives the system reset the block asked for. The running count can be read as two 16-bit halves.

Top module: `keyed_watchdog`

## Requirements
- R1: After `rst_n` is low at a clock edge, the control register reads 0x0000, both count halves read 0, and `wdt_irq` and `sys_rst_req` are low. After `por_n` is low, the cause register reads 0x0000.
- R2: `bus_sel` encodes the registers as follows: 0 is control, 1 is count low, 2 is count high and 3 is cause. A write to control updates it only when the two control writes immediately before it were 0x3333 and then 0xCCCC. Any other control write leaves the configuration unchanged.
- R3: A control write that breaks the unlock key returns the unlock detector to idle, so the key must be restarted. A repeated 0x3333 counts as a fresh first key word.
- R4: Two control writes, 0xAAAA and then 0x5555, when not unlocked, make the count read 0 after the second write and leave the control register unchanged.
- R5: Control bits 7:0 form a one-hot exponent select, where bit i selects exponent EXP_TAB[i]. With bit 15 (run) set, the timer expires 2^E clock edges after a restart (a configuration write or a keep-alive). On expiry the count returns to 0.
- R6: With the exponent field zero or holding more than one set bit, the counter never expires and keeps counting.
- R7: Expiry sets the interrupt flag. The flag is visible as control bit 12 and on `wdt_irq`. It is cleared only by an accepted configuration write with bit 12 set.
- R8: With control bit 14 set, expiry raises `sys_rst_req` for exactly one cycle. With bit 14 clear, `sys_rst_req` stays low.
- R9: Register 1 returns count bits 15:0, and register 2 returns count bits 31:16.
- R10: Cause register bit 0 is set by each reset request. It is unaffected by `rst_n`. It is cleared by writing 1 to that bit, and writing 0 there has no effect.
- R11: With run clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset for the cause register |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| wdt_irq | output | 1 | Interrupt flag |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A write takes effect at the rising edge where `bus_wr` is sampled, and read data follows `bus_sel` within the same cycle. The bench therefore drives on the falling edge and reads back one falling edge after each write. The count reads n after n rising edges from a restart. The flag and the reset request rise at edge 2^E, and the reset request falls one edge later. The bench waits exactly 2^E−1 cycles, checks that nothing has fired, and then checks again after one more edge. In the random phase, a bench model of both key detectors predicts the control readback after every write.

// File: rtl/kwd_pkg.sv
// Shared constants and types for the keyed watchdog.
// Assumes a 16-bit register bus and eight exponent select taps.
package kwd_pkg;

    localparam int unsigned DATA_W  = 16;
    localparam int unsigned NUM_SEL = 8;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_CNT_LO = 2'd1,
        REG_CNT_HI = 2'd2,
        REG_CAUSE  = 2'd3
    } reg_sel_e;

    localparam logic [DATA_W-1:0] KEY_OPEN_A = 16'h3333;
    localparam logic [DATA_W-1:0] KEY_OPEN_B = 16'hCCCC;
    localparam logic [DATA_W-1:0] KEY_KICK_A = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_KICK_B = 16'h5555;

    localparam int unsigned BIT_RUN   = 15;
    localparam int unsigned BIT_RSTEN = 14;
    localparam int unsigned BIT_FLAG  = 12;

    typedef enum logic [1:0] {
        UNL_IDLE = 2'd0,
        UNL_HALF = 2'd1,
        UNL_OPEN = 2'd2
    } unl_st_e;

    typedef enum logic {
        KA_IDLE = 1'b0,
        KA_HALF = 1'b1
    } ka_st_e;

endpackage

// File: rtl/kwd_keyseq.sv
// Key sequence detectors for the control register.
// Watches every control write. It flags the write that follows a complete
// unlock key as a configuration write, and it pulses kick on a complete
// keep-alive key. Outputs are combinational and valid in the cycle of the write.
// Assumes ctrl_wr is high for one cycle per write.
module kwd_keyseq
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              cfg_wr,
    output logic              kick
);

    unl_st_e unl_q, unl_d;
    ka_st_e  ka_q,  ka_d;

    // Next state of the unlock detector.
    always_comb begin
        unl_d = unl_q;
        if (ctrl_wr) begin
            case (unl_q)
                UNL_IDLE: unl_d = (wdata == KEY_OPEN_A) ? UNL_HALF : UNL_IDLE;
                UNL_HALF: begin
                    if (wdata == KEY_OPEN_B)      unl_d = UNL_OPEN;
                    else if (wdata == KEY_OPEN_A) unl_d = UNL_HALF;
                    else                          unl_d = UNL_IDLE;
                end
                default:  unl_d = UNL_IDLE;
            endcase
        end
    end

    // The write that follows a full unlock key carries the configuration.
    assign cfg_wr = ctrl_wr && (unl_q == UNL_OPEN);

    // Next state of the keep-alive detector and its kick pulse.
    always_comb begin
        ka_d = ka_q;
        kick = 1'b0;
        if (ctrl_wr) begin
            if (unl_q == UNL_OPEN) begin
                ka_d = KA_IDLE;
            end else begin
                case (ka_q)
                    KA_IDLE: ka_d = (wdata == KEY_KICK_A) ? KA_HALF : KA_IDLE;
                    default: begin
                        if (wdata == KEY_KICK_B) begin
                            kick = 1'b1;
                            ka_d = KA_IDLE;
                        end else if (wdata == KEY_KICK_A) begin
                            ka_d = KA_HALF;
                        end else begin
                            ka_d = KA_IDLE;
                        end
                    end
                endcase
            end
        end
    end

    // State registers of both detectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unl_q <= UNL_IDLE;
            ka_q  <= KA_IDLE;
        end else begin
            unl_q <= unl_d;
            ka_q  <= ka_d;
        end
    end

endmodule

// File: rtl/kwd_timebase.sv
// Watchdog counter with one-hot exponent compare.
// Counts while run is high. It flags expiry when the count reaches
// 2^EXP_TAB[i]-1 for the single selected tap i, and then wraps to zero.
// A zero or multi-hot select never expires. Restart has priority over expiry.
// Assumes every EXP_TAB entry is at most CNT_W.
module kwd_timebase
    import kwd_pkg::*;
#(
    parameter int unsigned CNT_W            = 32,
    parameter int unsigned EXP_TAB [NUM_SEL] = '{14, 24, 25, 26, 27, 28, 29, 30}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [NUM_SEL-1:0] exp_sel,
    input  logic               restart,
    output logic [CNT_W-1:0]   cnt,
    output logic               expire
);

    localparam logic [CNT_W-1:0] UNIT = 1;

    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_SEL-1:0] hit_vec;
    logic               sel_ok;

    // True when exactly one select bit is set.
    function automatic logic single_bit(input logic [NUM_SEL-1:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < NUM_SEL; i++) n += v[i];
        return (n == 1);
    endfunction

    // One terminal-count comparator per exponent tap.
    for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_tap
        localparam logic [CNT_W-1:0] LAST = (UNIT << EXP_TAB[gi]) - UNIT;
        assign hit_vec[gi] = exp_sel[gi] && (cnt_q == LAST);
    end

    assign sel_ok = single_bit(exp_sel);
    assign expire = run && sel_ok && (|hit_vec) && !restart;

    // Count register: restart, wrap on expiry, or advance while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || expire) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + UNIT;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/kwd_cause.sv
// Sticky reset-cause bit.
// Set by a reset request and cleared by a software write of one. Only the
// power-on reset clears it, so it survives the system reset it reports.
// Set wins over clear in the same cycle.
module kwd_cause (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    input  logic clr,
    output logic cause
);

    logic cause_q;

    // Hold the cause until software or power-on clears it.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cause_q <= 1'b0;
        end else if (set) begin
            cause_q <= 1'b1;
        end else if (clr) begin
            cause_q <= 1'b0;
        end
    end

    assign cause = cause_q;

endmodule

// File: rtl/keyed_watchdog.sv
// Keyed-access watchdog timer, top level.
// Decodes the register bus, holds the guarded configuration and the interrupt
// flag, and issues a one-cycle reset request on expiry when enabled.
// Assumes 17 <= CNT_W <= 32. Read data is combinational from bus_sel.
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int unsigned CNT_W            = 32,
    parameter int unsigned EXP_TAB [NUM_SEL] = '{14, 24, 25, 26, 27, 28, 29, 30}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_irq,
    output logic              sys_rst_req
);

    logic               ctrl_wr;
    logic               cause_wr;
    logic               cfg_wr;
    logic               kick;
    logic               expire;
    logic               run_q;
    logic               rsten_q;
    logic               flag_q;
    logic [NUM_SEL-1:0] exp_q;
    logic               rst_req_q;
    logic               cause;
    logic [CNT_W-1:0]   cnt_q;
    logic [31:0]        cnt_ext;

    assign ctrl_wr  = bus_wr && (bus_sel == REG_CTRL);
    assign cause_wr = bus_wr && (bus_sel == REG_CAUSE);

    kwd_keyseq u_keyseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wdata   (bus_wdata),
        .cfg_wr  (cfg_wr),
        .kick    (kick)
    );

    kwd_timebase #(
        .CNT_W   (CNT_W),
        .EXP_TAB (EXP_TAB)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .exp_sel (exp_q),
        .restart (cfg_wr || kick),
        .cnt     (cnt_q),
        .expire  (expire)
    );

    kwd_cause u_cause (
        .clk   (clk),
        .por_n (por_n),
        .set   (expire && rsten_q),
        .clr   (cause_wr && bus_wdata[0]),
        .cause (cause)
    );

    // Guarded configuration fields, loaded only by an unlocked write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            rsten_q <= 1'b0;
            exp_q   <= '0;
        end else if (cfg_wr) begin
            run_q   <= bus_wdata[BIT_RUN];
            rsten_q <= bus_wdata[BIT_RSTEN];
            exp_q   <= bus_wdata[NUM_SEL-1:0];
        end
    end

    // Interrupt flag: set on expiry, cleared by an unlocked write of one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (cfg_wr && bus_wdata[BIT_FLAG]) begin
            flag_q <= 1'b0;
        end
    end

    // One-cycle reset request on an enabled expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else begin
            rst_req_q <= expire && rsten_q;
        end
    end

    assign cnt_ext = 32'(cnt_q);

    // Read multiplexer over the four registers.
    always_comb begin
        bus_rdata = '0;
        case (bus_sel)
            REG_CTRL: begin
                bus_rdata[BIT_RUN]       = run_q;
                bus_rdata[BIT_RSTEN]     = rsten_q;
                bus_rdata[BIT_FLAG]      = flag_q;
                bus_rdata[NUM_SEL-1:0]   = exp_q;
            end
            REG_CNT_LO: bus_rdata = cnt_ext[15:0];
            REG_CNT_HI: bus_rdata = cnt_ext[31:16];
            default:    bus_rdata[0] = cause;
        endcase
    end

    assign wdt_irq     = flag_q;
    assign sys_rst_req = rst_req_q;

endmodule

// File: rtl/kwd_chk.sv
// Assertion checker for keyed_watchdog, attached by bind.
module kwd_chk
    import kwd_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sys_rst_req,
    input logic               wdt_irq,
    input logic               cause,
    input logic               cfg_wr,
    input logic               kick,
    input logic               expire,
    input logic               run,
    input logic               rsten,
    input logic [NUM_SEL-1:0] exp_sel,
    input logic [CNT_W-1:0]   cnt
);

    // R8
    rst_pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    // R8
    rst_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(rsten));

    // R7
    flag_after_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> wdt_irq);

    // R4
    kick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0));

    // R10
    cause_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> cause);

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(run) && $stable(rsten) && $stable(exp_sel)));

    // R6
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(exp_sel) != 1) |-> !expire);

    // R11
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !kick && !cfg_wr) |=> $stable(cnt));

endmodule

bind keyed_watchdog kwd_chk #(.CNT_W(CNT_W)) u_kwd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_rst_req (sys_rst_req),
    .wdt_irq     (wdt_irq),
    .cause       (cause),
    .cfg_wr      (cfg_wr),
    .kick        (kick),
    .expire      (expire),
    .run         (run_q),
    .rsten       (rsten_q),
    .exp_sel     (exp_q),
    .cnt         (cnt_q)
);

// File: tb/keyed_watchdog_tb.sv
`timescale 1ns/1ps
module keyed_watchdog_tb;

    localparam int unsigned TB_EXP [8] = '{2, 3, 4, 5, 6, 7, 8, 9};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        wdt_irq;
    logic        sys_rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    always #2.5 clk = ~clk;

    keyed_watchdog #(.CNT_W(32), .EXP_TAB(TB_EXP)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_n       (por_n),
        .bus_wr      (bus_wr),
        .bus_sel     (bus_sel),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_irq     (wdt_irq),
        .sys_rst_req (sys_rst_req)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        bus_wr = 1'b1;
        bus_sel = sel;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] d);
        bus_sel = sel;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic unlock_cfg(input logic [15:0] d);
        wr(2'd0, 16'h3333);
        wr(2'd0, 16'hCCCC);
        wr(2'd0, d);
    endtask

    // Bench model of the key detectors: returns the new masked config.
    function automatic logic [15:0] model_step(input logic [15:0] w, inout int unl,
                                               inout int ka, input logic [15:0] cfg);
        logic [15:0] nc;
        nc = cfg;
        if (unl == 2) begin
            nc = w & 16'hC0FF;
            unl = 0;
            ka = 0;
        end else begin
            if (unl == 0)      unl = (w == 16'h3333) ? 1 : 0;
            else               unl = (w == 16'hCCCC) ? 2 : ((w == 16'h3333) ? 1 : 0);
            ka = (w == 16'hAAAA) ? 1 : 0;
        end
        return nc;
    endfunction

    // Run-length guard.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc_cnt);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] m_cfg;
        int m_unl;
        int m_ka;
        int lim;

        void'($urandom(32'd20240611));
        cyc(4);
        rst_n = 1'b1;
        por_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(2'd0, d); check("R1 ctrl", d, 16'h0000);
        rd(2'd1, d); check("R1 cnt lo", d, 16'h0000);
        rd(2'd2, d); check("R1 cnt hi", d, 16'h0000);
        rd(2'd3, d); check("R1 cause", d, 16'h0000);
        check("R1 irq", wdt_irq, 0);
        check("R1 rst req", sys_rst_req, 0);

        // R2 plain write ignored, keyed write applied
        wr(2'd0, 16'h8001);
        rd(2'd0, d); check("R2 unkeyed", d, 16'h0000);
        unlock_cfg(16'h4002);
        rd(2'd0, d); check("R2 keyed", d, 16'h4002);

        // R3 broken key, then repeated first word
        wr(2'd0, 16'h3333); wr(2'd0, 16'h1234); wr(2'd0, 16'hCCCC); wr(2'd0, 16'h0004);
        rd(2'd0, d); check("R3 broken", d, 16'h4002);
        wr(2'd0, 16'h3333); wr(2'd0, 16'h3333); wr(2'd0, 16'hCCCC); wr(2'd0, 16'h4004);
        rd(2'd0, d); check("R3 repeat", d, 16'h4004);

        // R11 counter holds while run is clear
        cyc(10);
        rd(2'd1, d); check("R11 hold", d, 16'h0000);

        // R6 and R9: multi-hot select, count past 16 bits
        unlock_cfg(16'h8003);
        cyc(70000);
        rd(2'd1, d); check("R9 cnt lo", d, 16'd4464);
        rd(2'd2, d); check("R9 cnt hi", d, 16'd1);
        check("R6 no expiry", wdt_irq, 0);

        // R4 keep-alive restarts count, keeps config
        wr(2'd0, 16'hAAAA); wr(2'd0, 16'h5555);
        rd(2'd1, d); check("R4 cnt zero", d, 16'h0000);
        rd(2'd2, d); check("R4 cnt hi zero", d, 16'h0000);
        rd(2'd0, d); check("R4 cfg kept", d, 16'h8003);
        cyc(5);
        rd(2'd1, d); check("R4 counting", d, 16'd5);

        // R5 and R7: each exponent tap, flag cleared by keyed write
        for (int i = 0; i < 8; i++) begin
            unlock_cfg(16'h9000 | (16'h1 << i));
            check("R7 flag cleared", wdt_irq, 0);
            lim = 1 << TB_EXP[i];
            cyc(lim - 1);
            rd(2'd1, d); check("R5 before expiry cnt", d, 16'(lim - 1));
            check("R5 before expiry irq", wdt_irq, 0);
            cyc(1);
            check("R5 expiry irq", wdt_irq, 1);
            rd(2'd1, d); check("R5 wrap", d, 16'h0000);
            check("R8 no req without enable", sys_rst_req, 0);
        end

        // R8 reset request pulse; R7 flag kept when bit 12 not written
        unlock_cfg(16'hC001);
        check("R7 flag kept", wdt_irq, 1);
        cyc(3);
        check("R8 before", sys_rst_req, 0);
        cyc(1);
        check("R8 pulse", sys_rst_req, 1);
        rd(2'd3, d); check("R10 cause set", d, 16'h0001);
        cyc(1);
        check("R8 one cycle", sys_rst_req, 0);
        unlock_cfg(16'h1000);
        check("R7 cleared", wdt_irq, 0);

        // R10 cause survives system reset, write-one clear
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        rd(2'd3, d); check("R10 survives rst_n", d, 16'h0001);
        rd(2'd0, d); check("R1 ctrl after rst_n", d, 16'h0000);
        wr(2'd3, 16'h0000);
        rd(2'd3, d); check("R10 write zero", d, 16'h0001);
        wr(2'd3, 16'h0001);
        rd(2'd3, d); check("R10 write one", d, 16'h0000);
        unlock_cfg(16'hC001);
        cyc(4);
        rd(2'd3, d); check("R10 set again", d, 16'h0001);
        unlock_cfg(16'h0000);
        por_n = 1'b0;
        cyc(1);
        por_n = 1'b1;
        rd(2'd3, d); check("R1 cause after por_n", d, 16'h0000);

        // R2 and R3: random control writes against the bench model
        m_cfg = 16'h0000;
        m_unl = 0;
        m_ka = 0;
        for (int k = 0; k < 400; k++) begin
            logic [15:0] w;
            case ($urandom % 6)
                0: w = 16'h3333;
                1: w = 16'hCCCC;
                2: w = 16'hAAAA;
                3: w = 16'h5555;
                default: w = 16'($urandom);
            endcase
            wr(2'd0, w);
            m_cfg = model_step(w, m_unl, m_ka, m_cfg);
            rd(2'd0, d);
            check("R2 R3 random ctrl", d & 16'hC0FF, m_cfg);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule